// File: doc/BRIEF.md
# Flash Package Preamble Validator

This block checks the fixed sixteen-byte preamble at the start of a flash package. It takes bytes one at a time over a valid/ready handshake and builds the little-endian fields from them: a 32-bit identifying word, a 16-bit format version and a 16-bit image count. It runs a reflected byte-wise CRC-32 over those eight bytes and compares the result with the stored checksum word that follows them. The final four bytes hold the payload checksum. The block keeps that word so that a later payload checker can use it.

When the sixteenth byte has been taken, the block raises `done`. It then reports pass or fail, an error code, the version, the image count and the captured payload checksum. These results stay fixed until a synchronous `start` pulse clears the block and it accepts a new stream. Reading the flash device and walking the payload are handled elsewhere.

Top module: `flash_hdr_check`

## Requirements
- R1: Bytes are taken in stream order. Positions 0-3 are the identifying word, 4-5 the version, 6-7 the image count, 8-11 the stored header checksum and 12-15 the payload checksum. Each field arrives least significant byte first. At `done`, `hdrVersion`, `imageCount` and `payloadCrc` hold the assembled values.
- R2: If the identifying word is not 0x464C5348, the error code becomes 1.
- R3: If the version is not 0x0001, the error code becomes 2.
- R4: If the image count is zero, the error code becomes 4.
- R5: The checksum is a CRC-32 over positions 0-7 only. It starts at 0xFFFFFFFF, shifts each byte in LSB first with the reflected polynomial 0xEDB88320, and is inverted at the end. If the result differs from the word at positions 8-11, the error code becomes 3.
- R6: Only the first error detected in stream order is kept in `errCode`, and later errors do not replace it. The error code is 0 when no error has been found.
- R7: `done` rises on the clock edge that accepts the sixteenth byte and not before. It stays high until `start`. `pass` is high exactly when `done` is high and the error code is 0. The reported fields do not change while `done` is high.
- R8: `inReady` is low while `done` is high or `start` is high. A byte offered then is not taken and changes no output.
- R9: A `start` pulse clears `done`, the error code, every reported field, the CRC state and the byte position, including in the middle of a stream.
- R10: After reset, the outputs match the cleared state and `inReady` is high.
- R11: Idle cycles between bytes (valid low) do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous clear and restart |
| inValid | input | 1 | Byte on `inData` is valid |
| inData | input | 8 | Stream byte |
| inReady | output | 1 | Block accepts a byte this cycle |
| done | output | 1 | All sixteen bytes consumed |
| pass | output | 1 | Done with no error |
| errCode | output | 3 | 0 none, 1 identifier, 2 version, 3 checksum, 4 zero count |
| hdrVersion | output | 16 | Assembled version |
| imageCount | output | 16 | Assembled image count |
| payloadCrc | output | 32 | Captured payload checksum word |

## Verification
The first pattern is a well-formed preamble with unlike bytes in every field. It shows whether byte order and field positions are right, and whether the CRC really covers only the first eight bytes. Each single-fault stream (wrong identifier, wrong version, zero count, one flipped checksum bit) must produce its own code. Streams with several faults show whether the earliest fault wins. Streams sent with idle gaps, restarted part-way through, or followed by extra bytes after completion check the handshake, the clear and the freeze of the results.

// File: rtl/flash_hdr_pkg.sv
package flash_hdr_pkg;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned HDR_BYTES  = 8;
  localparam int unsigned TOTAL_BYTES = 16;
  localparam int unsigned POS_W      = $clog2(TOTAL_BYTES);

  // byte positions whose acceptance completes a field
  localparam int unsigned POS_MAGIC_END = 3;
  localparam int unsigned POS_VER_END   = 5;
  localparam int unsigned POS_CNT_END   = 7;
  localparam int unsigned POS_HSUM_END  = 11;
  localparam int unsigned POS_PSUM_END  = 15;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_MAGIC   = 3'd1,
    ERR_VERSION = 3'd2,
    ERR_CRC     = 3'd3,
    ERR_COUNT   = 3'd4
  } err_e;

  typedef struct packed {
    logic accept;
    logic clear;
    logic crcEn;
    logic chkMagic;
    logic chkVer;
    logic chkCount;
    logic chkCrc;
    logic capPay;
  } strobe_t;

  function automatic logic [WORD_W-1:0] crcStep(
    input logic [WORD_W-1:0] crcIn,
    input logic [BYTE_W-1:0] dataIn,
    input logic [WORD_W-1:0] polyRefl
  );
    logic [WORD_W-1:0] c;
    c = crcIn ^ {{(WORD_W-BYTE_W){1'b0}}, dataIn};
    for (int k = 0; k < BYTE_W; k++) begin
      c = c[0] ? ((c >> 1) ^ polyRefl) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/flash_hdr_ctrl.sv
module flash_hdr_ctrl
  import flash_hdr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    inValid,
  output logic    inReady,
  output logic    done,
  output strobe_t strobes
);

  logic [POS_W-1:0] posReg;
  logic             doneReg;
  logic             takeByte;

  assign inReady  = !doneReg && !start;
  assign takeByte = inValid && inReady;
  assign done     = doneReg;

  always_comb begin
    strobes          = '0;
    strobes.clear    = start;
    strobes.accept   = takeByte;
    strobes.crcEn    = takeByte && (32'(posReg) < HDR_BYTES);
    strobes.chkMagic = takeByte && (32'(posReg) == POS_MAGIC_END);
    strobes.chkVer   = takeByte && (32'(posReg) == POS_VER_END);
    strobes.chkCount = takeByte && (32'(posReg) == POS_CNT_END);
    strobes.chkCrc   = takeByte && (32'(posReg) == POS_HSUM_END);
    strobes.capPay   = takeByte && (32'(posReg) == POS_PSUM_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posReg  <= '0;
      doneReg <= 1'b0;
    end else if (start) begin
      posReg  <= '0;
      doneReg <= 1'b0;
    end else if (takeByte) begin
      posReg <= posReg + 1'b1;
      if (32'(posReg) == TOTAL_BYTES - 1) begin
        doneReg <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_hdr_dpath.sv
module flash_hdr_dpath
  import flash_hdr_pkg::*;
#(
  parameter logic [WORD_W-1:0] MAGIC_VAL   = 32'h464C_5348,
  parameter logic [HALF_W-1:0] VERSION_VAL = 16'h0001,
  parameter logic [WORD_W-1:0] CRC_POLY_R  = 32'hEDB8_8320,
  parameter logic [WORD_W-1:0] CRC_INIT    = 32'hFFFF_FFFF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [BYTE_W-1:0] inData,
  output err_e              errCode,
  output logic [HALF_W-1:0] hdrVersion,
  output logic [HALF_W-1:0] imageCount,
  output logic [WORD_W-1:0] payloadCrc
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] crcReg;
  logic [WORD_W-1:0] nextWord;
  err_e              errReg;
  err_e              newErr;

  // little-endian: each new byte enters at the top, older bytes move down
  assign nextWord = {inData, shiftReg[WORD_W-1:BYTE_W]};

  always_comb begin
    newErr = ERR_NONE;
    if (strobes.chkMagic && (nextWord != MAGIC_VAL)) begin
      newErr = ERR_MAGIC;
    end else if (strobes.chkVer && (nextWord[WORD_W-1:HALF_W] != VERSION_VAL)) begin
      newErr = ERR_VERSION;
    end else if (strobes.chkCount && (nextWord[WORD_W-1:HALF_W] == '0)) begin
      newErr = ERR_COUNT;
    end else if (strobes.chkCrc && (nextWord != ~crcReg)) begin
      newErr = ERR_CRC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg   <= '0;
      crcReg     <= CRC_INIT;
      errReg     <= ERR_NONE;
      hdrVersion <= '0;
      imageCount <= '0;
      payloadCrc <= '0;
    end else if (strobes.clear) begin
      shiftReg   <= '0;
      crcReg     <= CRC_INIT;
      errReg     <= ERR_NONE;
      hdrVersion <= '0;
      imageCount <= '0;
      payloadCrc <= '0;
    end else if (strobes.accept) begin
      shiftReg <= nextWord;
      if (strobes.crcEn) begin
        crcReg <= crcStep(crcReg, inData, CRC_POLY_R);
      end
      if (strobes.chkVer) begin
        hdrVersion <= nextWord[WORD_W-1:HALF_W];
      end
      if (strobes.chkCount) begin
        imageCount <= nextWord[WORD_W-1:HALF_W];
      end
      if (strobes.capPay) begin
        payloadCrc <= nextWord;
      end
      if ((errReg == ERR_NONE) && (newErr != ERR_NONE)) begin
        errReg <= newErr;
      end
    end
  end

  assign errCode = errReg;

endmodule

// File: rtl/flash_hdr_check.sv
module flash_hdr_check
  import flash_hdr_pkg::*;
#(
  parameter logic [31:0] MAGIC_VAL   = 32'h464C_5348,
  parameter logic [15:0] VERSION_VAL = 16'h0001
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        inValid,
  input  logic [7:0]  inData,
  output logic        inReady,
  output logic        done,
  output logic        pass,
  output logic [2:0]  errCode,
  output logic [15:0] hdrVersion,
  output logic [15:0] imageCount,
  output logic [31:0] payloadCrc
);

  strobe_t strobes;
  err_e    errVal;

  flash_hdr_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .inValid (inValid),
    .inReady (inReady),
    .done    (done),
    .strobes (strobes)
  );

  flash_hdr_dpath #(
    .MAGIC_VAL   (MAGIC_VAL),
    .VERSION_VAL (VERSION_VAL)
  ) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .inData     (inData),
    .errCode    (errVal),
    .hdrVersion (hdrVersion),
    .imageCount (imageCount),
    .payloadCrc (payloadCrc)
  );

  assign errCode = errVal;
  assign pass    = done && (errVal == ERR_NONE);

endmodule

// File: rtl/flash_hdr_check_sva.sv
module flash_hdr_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        inReady,
  input logic        done,
  input logic [2:0]  errCode,
  input logic [15:0] hdrVersion,
  input logic [15:0] imageCount,
  input logic [31:0] payloadCrc
);

  p_ready_low_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !inReady);

  p_ready_high_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !start) |-> inReady);

  p_err_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (errCode != 3'd0 && !start) |=> (errCode == $past(errCode)));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_fields_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(payloadCrc) && $stable(hdrVersion) && $stable(imageCount)));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && errCode == 3'd0 && hdrVersion == 16'd0 &&
               imageCount == 16'd0 && payloadCrc == 32'd0));

  p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    errCode <= 3'd4);

endmodule

bind flash_hdr_check flash_hdr_check_sva chk_i (.*);

// File: tb/flash_hdr_check_tb_top.sv
module flash_hdr_check_tb_top;

  localparam logic [31:0] GOOD_MAGIC = 32'h464C_5348;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady, done, pass;
  logic [2:0]  errCode;
  logic [15:0] hdrVersion, imageCount;
  logic [31:0] payloadCrc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] frame [16];

  always #2 clk = ~clk;

  flash_hdr_check dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .inValid(inValid), .inData(inData),
    .inReady(inReady), .done(done), .pass(pass), .errCode(errCode),
    .hdrVersion(hdrVersion), .imageCount(imageCount), .payloadCrc(payloadCrc)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<50000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // bit-serial reference checksum over the first eight bytes
  function automatic logic [31:0] refCrc(input logic [7:0] b [16]);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[i][j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic build(input logic [31:0] magic, input logic [15:0] ver,
                       input logic [15:0] cnt, input logic [31:0] pay,
                       input logic [31:0] crcFlip);
    logic [31:0] hs;
    for (int i = 0; i < 4; i++) frame[i] = magic[8*i +: 8];
    for (int i = 0; i < 2; i++) frame[4+i] = ver[8*i +: 8];
    for (int i = 0; i < 2; i++) frame[6+i] = cnt[8*i +: 8];
    hs = refCrc(frame) ^ crcFlip;
    for (int i = 0; i < 4; i++) frame[8+i] = hs[8*i +: 8];
    for (int i = 0; i < 4; i++) frame[12+i] = pay[8*i +: 8];
  endtask

  // called at a negedge; returns at a negedge
  task automatic sendBytes(input int first, input int last, input int gap);
    for (int i = first; i <= last; i++) begin
      inData  = frame[i];
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 done", {31'd0, done}, 32'd0);
    chk("R10 ready", {31'd0, inReady}, 32'd1);
    chk("R10 err", {29'd0, errCode}, 32'd0);
    chk("R10 fields", {hdrVersion, imageCount} | payloadCrc, 32'd0);
  endtask

  task automatic t_good();
    pulseStart();
    build(GOOD_MAGIC, 16'h0001, 16'h0003, 32'hA5C3_0F17, 32'd0);
    sendBytes(0, 15, 0);
    chk("R7 done", {31'd0, done}, 32'd1);
    chk("R7 pass", {31'd0, pass}, 32'd1);
    chk("R5 err none", {29'd0, errCode}, 32'd0);
    chk("R1 version", {16'd0, hdrVersion}, 32'h0001);
    chk("R1 count", {16'd0, imageCount}, 32'h0003);
    chk("R1 payload", payloadCrc, 32'hA5C3_0F17);
  endtask

  task automatic t_gaps();
    pulseStart();
    build(GOOD_MAGIC, 16'h0001, 16'h1234, 32'h0102_0304, 32'd0);
    sendBytes(0, 14, 2);
    chk("R7 not done early", {31'd0, done}, 32'd0);
    sendBytes(15, 15, 0);
    chk("R11 pass with gaps", {31'd0, pass}, 32'd1);
    chk("R11 count", {16'd0, imageCount}, 32'h1234);
    chk("R11 payload", payloadCrc, 32'h0102_0304);
  endtask

  task automatic t_single(input string req, input logic [31:0] magic, input logic [15:0] ver,
                          input logic [15:0] cnt, input logic [31:0] flip, input logic [2:0] code);
    pulseStart();
    build(magic, ver, cnt, 32'h5555_AAAA, flip);
    sendBytes(0, 15, 0);
    chk({req, " code"}, {29'd0, errCode}, {29'd0, code});
    chk({req, " done/pass"}, {30'd0, done, pass}, 32'd2);
  endtask

  task automatic t_ignore();
    pulseStart();
    build(GOOD_MAGIC, 16'h0001, 16'h0007, 32'hDEAD_BEEF, 32'd0);
    sendBytes(0, 15, 0);
    chk("R8 ready low after done", {31'd0, inReady}, 32'd0);
    for (int i = 0; i < 4; i++) frame[12+i] = 8'h11;
    sendBytes(12, 15, 0);
    chk("R8 payload unchanged", payloadCrc, 32'hDEAD_BEEF);
    chk("R8 done held", {31'd0, pass}, 32'd1);
    start = 1'b1;
    #1;
    chk("R8 ready low in start", {31'd0, inReady}, 32'd0);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_restart();
    pulseStart();
    build(32'h0000_0000, 16'h0009, 16'h0004, 32'h1111_2222, 32'd0);
    sendBytes(0, 7, 0);
    chk("R9 mid error seen", {29'd0, errCode}, 32'd1);
    pulseStart();
    chk("R9 cleared err", {29'd0, errCode}, 32'd0);
    chk("R9 cleared fields", {hdrVersion, imageCount}, 32'd0);
    build(GOOD_MAGIC, 16'h0001, 16'h0002, 32'h7766_5544, 32'd0);
    sendBytes(0, 15, 1);
    chk("R9 pass after restart", {31'd0, pass}, 32'd1);
    chk("R9 payload after restart", payloadCrc, 32'h7766_5544);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_gaps();
    t_single("R2 bad magic", 32'h464C_5349, 16'h0001, 16'h0001, 32'd0, 3'd1);
    t_single("R3 bad version", GOOD_MAGIC, 16'h0100, 16'h0001, 32'd0, 3'd2);
    t_single("R4 zero count", GOOD_MAGIC, 16'h0001, 16'h0000, 32'd0, 3'd4);
    t_single("R5 crc flip", GOOD_MAGIC, 16'h0001, 16'h0001, 32'h0000_0100, 3'd3);
    t_single("R6 magic first", 32'h1234_5678, 16'h0002, 16'h0000, 32'h8000_0000, 3'd1);
    t_single("R6 version first", GOOD_MAGIC, 16'h0002, 16'h0000, 32'h0000_0001, 3'd2);
    t_single("R6 count before crc", GOOD_MAGIC, 16'h0001, 16'h0000, 32'h0000_0010, 3'd4);
    t_ignore();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule